// File: doc/BRIEF.md
# Oscillator Trim Search Controller

This controller tunes an on-chip oscillator toward a requested cycle count. It drives two trim codes, a 5-bit coarse divider and a 6-bit fine calibration code, both packed into one oscillator control word. For every step it offers a measurement request to an external frequency meter. It waits for the meter's count and compares that count with the target. The target count is the wanted frequency in Hz divided by 26000, which is the number of oscillator cycles the meter sees in its fixed gate window.

The search is linear and runs in two stages. It starts with both codes at their midpoints and first walks the coarse divider one step at a time, toward the target. When two consecutive counts fall on opposite sides of the target, it keeps the setting that gave the higher count and moves to the fine code. The next such crossing ends the search. The chosen setting is then measured once more and that count is reported. A step out of a code's legal range, or a zero count from the meter, ends the search with a zero result and the fail flag.

Both meter channels use valid/ready. A request is offered with `meas_req_valid` and must stay offered, with an unchanged control word, until the meter raises `meas_req_ready`. After that the controller holds `meas_res_ready` high until a result arrives, and it never has more than one request outstanding. The meter may stall either channel for as long as it likes.

Top module: `osc_trim_search`

## Requirements
- R1: After reset no request is offered, `done` and `fail` are low, and the control word carries divider 16 and calibration 32.
- R2: The control word places the calibration code in bits [5:0], a 7-bit current band field fixed at 4 in bits [12:6], a 4-bit frequency band field fixed at 0 in bits [16:13], and the divider in bits [21:17]. Bit 22 and bits [31:24] are zero, and the charge-pump enable in bit 23 is one.
- R3: A request stays valid with a stable control word until it is accepted. A result is accepted only while `meas_res_ready` is high, and `meas_res_ready` is never high together with `meas_req_valid`.
- R4: A `start` pulse while idle begins a search in the coarse stage from divider 16 and calibration 32. A `start` pulse during a search has no effect on its outcome and produces no second completion.
- R5: After each nonzero count, the active code moves by +1, 0 or -1, following the sign of (target - count). The first count of a search is never compared against a previous one.
- R6: When the previous and the current count lie on opposite sides of the target (their signs of (target - count) differ), the setting with the higher count is kept. The first such crossing switches the search to the fine code.
- R7: A crossing in the fine stage ends the search. The kept setting is requested once more, its count is reported on `final_count` with a one-cycle `done`, and the control word keeps that setting afterwards.
- R8: A step that would take the divider below 0 or above 31, or the calibration code below 0 or above 63, ends the search with `final_count` 0 and `done` and `fail` both high.
- R9: A count of zero at any measurement ends the search with `final_count` 0 and `done` and `fail` both high.
- R10: `done` and `fail` are single-cycle pulses. `fail` is high only together with `done`, and exactly when the reported count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a search when idle |
| target_count | input | COUNT_W | Wanted meter count, held for the whole search |
| meas_req_valid | output | 1 | Measurement request offered |
| meas_req_ready | input | 1 | Meter accepts the request |
| meas_res_valid | input | 1 | Meter result present |
| meas_res_ready | output | 1 | Controller can take a result |
| meas_res_count | input | COUNT_W | Measured count |
| ctrl_word | output | CTRL_W | Packed oscillator control word |
| final_count | output | COUNT_W | Count of the chosen setting, zero on failure |
| done | output | 1 | Search complete pulse |
| fail | output | 1 | Search aborted pulse |

## Verification
The checker assumes a meter that returns at most one result per accepted request and never asserts a result before it has taken a request. It also assumes that `target_count` does not change during a search, and that the target is never exactly equal to a count reachable after a crossing. An exact hit after a crossing makes the step zero and the search repeat forever. The bench meter follows this contract and applies varying stalls on both channels. The bench oscillator model is monotonic in both codes, and the targets are chosen so that no visited setting gives exactly the target.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [1:0] {
    SGN_ZERO = 2'd0,
    SGN_POS  = 2'd1,
    SGN_NEG  = 2'd2
  } sgn_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FREQ  = 3'd3,
    ST_FWAIT = 3'd4
  } state_t;

  typedef enum logic {
    STG_COARSE = 1'b0,
    STG_FINE   = 1'b1
  } stage_t;

  localparam int IBAND_W = 7;
  localparam int FBAND_W = 4;
  localparam logic [IBAND_W-1:0] IBAND_VAL = 7'd4;
  localparam logic [FBAND_W-1:0] FBAND_VAL = 4'd0;

endpackage

// File: rtl/osc_ctrl_pack.sv
module osc_ctrl_pack
  import osc_trim_pkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int CALI_W = 6,
  parameter int CTRL_W = 32
) (
  input  logic [DIV_W-1:0]  div_code,
  input  logic [CALI_W-1:0] cali_code,
  output logic [CTRL_W-1:0] word
);
  localparam int IBAND_LSB = CALI_W;
  localparam int FBAND_LSB = IBAND_LSB + IBAND_W;
  localparam int DIV_LSB   = FBAND_LSB + FBAND_W;
  localparam int CP_BIT    = DIV_LSB + DIV_W + 1;

  always_comb begin
    word = '0;
    word[CALI_W-1:0]            = cali_code;
    word[IBAND_LSB +: IBAND_W]  = IBAND_VAL;
    word[FBAND_LSB +: FBAND_W]  = FBAND_VAL;
    word[DIV_LSB +: DIV_W]      = div_code;
    word[CP_BIT]                = 1'b1;
  end
endmodule

// File: rtl/osc_trim_cmp.sv
module osc_trim_cmp
  import osc_trim_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic [COUNT_W-1:0] target,
  input  logic [COUNT_W-1:0] cur_cnt,
  input  logic [COUNT_W-1:0] prev_cnt,
  input  logic               prev_ok,
  output sgn_t               cur_sgn,
  output sgn_t               prev_sgn,
  output logic               crossing,
  output logic               prev_higher
);
  function automatic sgn_t sign_of(input logic [COUNT_W-1:0] t,
                                   input logic [COUNT_W-1:0] c);
    if (t > c)      return SGN_POS;
    else if (t < c) return SGN_NEG;
    else            return SGN_ZERO;
  endfunction

  always_comb begin
    cur_sgn     = sign_of(target, cur_cnt);
    prev_sgn    = sign_of(target, prev_cnt);
    crossing    = prev_ok && (cur_sgn != prev_sgn);
    prev_higher = prev_cnt > cur_cnt;
  end
endmodule

// File: rtl/osc_trim_step.sv
module osc_trim_step
  import osc_trim_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic [PW-1:0] param,
  input  sgn_t          dir,
  input  logic [PW:0]   limit,
  output logic [PW-1:0] next,
  output logic          oob
);
  logic signed [PW+1:0] sum;
  logic signed [PW+1:0] lim_s;

  always_comb begin
    lim_s = $signed({1'b0, limit});
    unique case (dir)
      SGN_POS: sum = $signed({2'b00, param}) + (PW+2)'(1);
      SGN_NEG: sum = $signed({2'b00, param}) - (PW+2)'(1);
      default: sum = $signed({2'b00, param});
    endcase
    oob  = (sum < 0) || (sum >= lim_s);
    next = sum[PW-1:0];
  end
endmodule

// File: rtl/osc_trim_search.sv
module osc_trim_search
  import osc_trim_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int DIV_W   = 5,
  parameter int CALI_W  = 6,
  parameter int CTRL_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COUNT_W-1:0] target_count,
  output logic               meas_req_valid,
  input  logic               meas_req_ready,
  input  logic               meas_res_valid,
  output logic               meas_res_ready,
  input  logic [COUNT_W-1:0] meas_res_count,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic [COUNT_W-1:0] final_count,
  output logic               done,
  output logic               fail
);
  localparam int PW       = (DIV_W > CALI_W) ? DIV_W : CALI_W;
  localparam int DIV_LIMI = 1 << DIV_W;
  localparam int CALI_LIMI = 1 << CALI_W;
  localparam logic [PW:0] DIV_LIM  = (PW+1)'(DIV_LIMI);
  localparam logic [PW:0] CALI_LIM = (PW+1)'(CALI_LIMI);
  localparam logic [DIV_W-1:0]  DIV_MID  = DIV_W'(DIV_LIMI / 2);
  localparam logic [CALI_W-1:0] CALI_MID = CALI_W'(CALI_LIMI / 2);

  state_t state_q;
  stage_t stage_q;

  logic [DIV_W-1:0]   cur_div_q,  prev_div_q;
  logic [CALI_W-1:0]  cur_cali_q, prev_cali_q;
  logic [COUNT_W-1:0] prev_cnt_q;
  logic               prev_ok_q;

  // comparison of the fresh result with the previous step
  sgn_t cur_sgn, prev_sgn;
  logic crossing, prev_higher;

  osc_trim_cmp #(.COUNT_W(COUNT_W)) u_cmp (
    .target     (target_count),
    .cur_cnt    (meas_res_count),
    .prev_cnt   (prev_cnt_q),
    .prev_ok    (prev_ok_q),
    .cur_sgn    (cur_sgn),
    .prev_sgn   (prev_sgn),
    .crossing   (crossing),
    .prev_higher(prev_higher)
  );

  // setting kept after this result
  logic               keep_prev;
  logic [DIV_W-1:0]   sel_div;
  logic [CALI_W-1:0]  sel_cali;
  logic [COUNT_W-1:0] sel_cnt;
  sgn_t               sel_sgn;
  stage_t             next_stage;
  logic               finish;

  always_comb begin
    keep_prev  = crossing && prev_higher;
    sel_div    = keep_prev ? prev_div_q  : cur_div_q;
    sel_cali   = keep_prev ? prev_cali_q : cur_cali_q;
    sel_cnt    = keep_prev ? prev_cnt_q  : meas_res_count;
    sel_sgn    = keep_prev ? prev_sgn    : cur_sgn;
    next_stage = crossing ? STG_FINE : stage_q;
    finish     = crossing && (stage_q == STG_FINE);
  end

  // one stepper, shared by both codes
  logic [PW-1:0] step_in, step_out;
  logic [PW:0]   step_lim;
  logic          step_oob;

  always_comb begin
    if (next_stage == STG_COARSE) begin
      step_in  = PW'(sel_div);
      step_lim = DIV_LIM;
    end else begin
      step_in  = PW'(sel_cali);
      step_lim = CALI_LIM;
    end
  end

  osc_trim_step #(.PW(PW)) u_step (
    .param(step_in),
    .dir  (sel_sgn),
    .limit(step_lim),
    .next (step_out),
    .oob  (step_oob)
  );

  osc_ctrl_pack #(.DIV_W(DIV_W), .CALI_W(CALI_W), .CTRL_W(CTRL_W)) u_pack (
    .div_code (cur_div_q),
    .cali_code(cur_cali_q),
    .word     (ctrl_word)
  );

  assign meas_req_valid = (state_q == ST_REQ)  || (state_q == ST_FREQ);
  assign meas_res_ready = (state_q == ST_WAIT) || (state_q == ST_FWAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      stage_q     <= STG_COARSE;
      cur_div_q   <= DIV_MID;
      cur_cali_q  <= CALI_MID;
      prev_div_q  <= '0;
      prev_cali_q <= '0;
      prev_cnt_q  <= '0;
      prev_ok_q   <= 1'b0;
      final_count <= '0;
      done        <= 1'b0;
      fail        <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            stage_q    <= STG_COARSE;
            cur_div_q  <= DIV_MID;
            cur_cali_q <= CALI_MID;
            prev_ok_q  <= 1'b0;
            state_q    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (meas_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (meas_res_valid) begin
            if (meas_res_count == '0) begin
              final_count <= '0;
              done        <= 1'b1;
              fail        <= 1'b1;
              state_q     <= ST_IDLE;
            end else if (finish) begin
              cur_div_q  <= sel_div;
              cur_cali_q <= sel_cali;
              state_q    <= ST_FREQ;
            end else if (step_oob) begin
              final_count <= '0;
              done        <= 1'b1;
              fail        <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              prev_div_q  <= sel_div;
              prev_cali_q <= sel_cali;
              prev_cnt_q  <= sel_cnt;
              prev_ok_q   <= 1'b1;
              stage_q     <= next_stage;
              cur_div_q   <= (next_stage == STG_COARSE) ? step_out[DIV_W-1:0] : sel_div;
              cur_cali_q  <= (next_stage == STG_FINE) ? step_out[CALI_W-1:0] : sel_cali;
              state_q     <= ST_REQ;
            end
          end
        end
        ST_FREQ: begin
          if (meas_req_ready) state_q <= ST_FWAIT;
        end
        ST_FWAIT: begin
          if (meas_res_valid) begin
            final_count <= meas_res_count;
            done        <= 1'b1;
            fail        <= (meas_res_count == '0);
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/osc_trim_search_chk.sv
module osc_trim_search_chk
  import osc_trim_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int DIV_W   = 5,
  parameter int CALI_W  = 6,
  parameter int CTRL_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               meas_req_valid,
  input logic               meas_req_ready,
  input logic               meas_res_ready,
  input logic [CTRL_W-1:0]  ctrl_word,
  input logic [COUNT_W-1:0] final_count,
  input logic               done,
  input logic               fail
);
  localparam int IBAND_LSB = CALI_W;
  localparam int FBAND_LSB = IBAND_LSB + IBAND_W;
  localparam int DIV_LSB   = FBAND_LSB + FBAND_W;
  localparam int RSV_BIT   = DIV_LSB + DIV_W;
  localparam int CP_BIT    = RSV_BIT + 1;

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req_valid && !meas_req_ready |=> meas_req_valid && $stable(ctrl_word));

  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    meas_res_ready |-> !meas_req_valid);

  a_r2_fixed_fields: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req_valid |-> (ctrl_word[IBAND_LSB +: IBAND_W] == IBAND_VAL) &&
                       (ctrl_word[FBAND_LSB +: FBAND_W] == FBAND_VAL) &&
                       ctrl_word[CP_BIT] && !ctrl_word[RSV_BIT]);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  a_r8_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && fail |-> final_count == '0);

  a_r7_ok_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> final_count != '0);

  a_r4_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !meas_req_valid && !meas_res_ready);
endmodule

bind osc_trim_search osc_trim_search_chk #(
  .COUNT_W(COUNT_W), .DIV_W(DIV_W), .CALI_W(CALI_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .meas_req_valid(meas_req_valid),
  .meas_req_ready(meas_req_ready),
  .meas_res_ready(meas_res_ready),
  .ctrl_word     (ctrl_word),
  .final_count   (final_count),
  .done          (done),
  .fail          (fail)
);

// File: tb/osc_trim_search_bench.sv
module osc_trim_search_bench;
  localparam int COUNT_W = 16;
  localparam int CTRL_W  = 32;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [COUNT_W-1:0] target_count = '0;
  logic               meas_req_valid;
  logic               meas_req_ready = 1'b0;
  logic               meas_res_valid = 1'b0;
  logic               meas_res_ready;
  logic [COUNT_W-1:0] meas_res_count = '0;
  logic [CTRL_W-1:0]  ctrl_word;
  logic [COUNT_W-1:0] final_count;
  logic               done;
  logic               fail;

  always #5 clk = ~clk;

  osc_trim_search u_osc_trim_search (
    .clk(clk), .rst_n(rst_n), .start(start), .target_count(target_count),
    .meas_req_valid(meas_req_valid), .meas_req_ready(meas_req_ready),
    .meas_res_valid(meas_res_valid), .meas_res_ready(meas_res_ready),
    .meas_res_count(meas_res_count), .ctrl_word(ctrl_word),
    .final_count(final_count), .done(done), .fail(fail)
  );

  int n_checks = 0;
  int n_fails  = 0;
  int n_done   = 0;

  // oscillator model controls
  int g_gain      = 520;
  int g_zero_at   = -1;
  bit g_cali_dead = 1'b0;
  int g_meas_idx  = 0;

  typedef struct { int cnt; bit fl; int d; int c; } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int osc_model(input int d, input int c, input int idx);
    int cc;
    if (idx == g_zero_at) return 0;
    cc = g_cali_dead ? 32 : c;
    return (g_gain * (d + 4) * (200 + cc)) / 256;
  endfunction

  function automatic int sgn(input int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  // reference search built from the requirements
  function automatic exp_t ref_search(input int tgt);
    exp_t r;
    int d = 16, c = 32, f = 0, pd = 0, pc = 0, pf = 0, n = 0, p = 0;
    bit pv = 0, fine = 0;
    r.cnt = 0; r.fl = 1; r.d = -1; r.c = -1;
    for (int it = 0; it < 400; it++) begin
      f = osc_model(d, c, n); n++;
      if (f == 0) return r;
      if (pv && sgn(tgt - f) != sgn(tgt - pf)) begin
        if (pf > f) begin d = pd; c = pc; f = pf; end
        if (fine) begin
          r.cnt = osc_model(d, c, n);
          r.fl = (r.cnt == 0);
          r.d = d; r.c = c;
          return r;
        end
        fine = 1;
      end
      pd = d; pc = c; pf = f; pv = 1;
      p = (fine ? c : d) + sgn(tgt - f);
      if (p < 0 || p >= (fine ? 64 : 32)) return r;
      if (fine) c = p; else d = p;
    end
    return r;
  endfunction

  // meter model with varying stalls; checks each offered word (R2)
  initial begin
    forever begin
      @(negedge clk);
      if (meas_req_valid && rst_n) begin
        repeat (g_meas_idx % 2) @(negedge clk);
        check(ctrl_word[12:6] == 7'd4 && ctrl_word[16:13] == 4'd0 &&
              ctrl_word[23] && !ctrl_word[22] && ctrl_word[31:24] == 8'd0,
              "R2 fixed fields", int'(ctrl_word), 0);
        meas_res_count = COUNT_W'(osc_model(int'(ctrl_word[21:17]),
                                            int'(ctrl_word[5:0]), g_meas_idx));
        meas_req_ready = 1'b1;
        @(negedge clk);
        meas_req_ready = 1'b0;
        repeat (g_meas_idx % 3) @(negedge clk);
        meas_res_valid = 1'b1;
        @(negedge clk);
        meas_res_valid = 1'b0;
        g_meas_idx++;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        exp_t e;
        n_done++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected completion", 1, 0);
        end else begin
          e = exp_q.pop_front();
          check(int'(final_count) == e.cnt, e.fl ? "R8/R9 final count" : "R7 final count",
                int'(final_count), e.cnt);
          check(fail == e.fl, "R10 fail flag", int'(fail), int'(e.fl));
          if (!e.fl) begin
            check(int'(ctrl_word[21:17]) == e.d, "R6 kept divider", int'(ctrl_word[21:17]), e.d);
            check(int'(ctrl_word[5:0]) == e.c, "R5 kept calibration", int'(ctrl_word[5:0]), e.c);
          end
        end
      end
    end
  end

  task automatic run_case(input int tgt, input int gain, input int zero_at,
                          input bit dead, input bit extra_start);
    exp_t e;
    int want;
    g_gain = gain; g_zero_at = zero_at; g_cali_dead = dead; g_meas_idx = 0;
    e = ref_search(tgt);
    exp_q.push_back(e);
    want = n_done + 1;
    @(negedge clk);
    target_count = COUNT_W'(tgt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (n_done < want) @(negedge clk);
    repeat (30) @(negedge clk);
    check(n_done == want, "R4 single completion", n_done, want);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!meas_req_valid, "R1 no request", int'(meas_req_valid), 0);
    check(!done && !fail, "R1 flags low", int'({done, fail}), 0);
    check(int'(ctrl_word[21:17]) == 16, "R1 divider mid", int'(ctrl_word[21:17]), 16);
    check(int'(ctrl_word[5:0]) == 32, "R1 calibration mid", int'(ctrl_word[5:0]), 32);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_case(9615, 520, -1, 1'b0, 1'b0);   // R5 R6 R7 coarse up then fine down
    run_case(12692, 520, -1, 1'b0, 1'b0);  // R7 higher target
    run_case(7000, 520, -1, 1'b0, 1'b0);   // R5 coarse down
    run_case(5000, 300, -1, 1'b0, 1'b0);   // R6 keep higher previous
    run_case(12692, 520, -1, 1'b0, 1'b1);  // R4 start ignored while busy
    run_case(60000, 520, -1, 1'b0, 1'b0);  // R8 divider above 31
    run_case(5, 520, -1, 1'b0, 1'b0);      // R8 divider below 0
    run_case(9615, 520, -1, 1'b1, 1'b0);   // R8 calibration out of range
    run_case(9615, 520, 0, 1'b0, 1'b0);    // R9 zero on first count
    run_case(9615, 520, 3, 1'b0, 1'b0);    // R9 zero in fine stage
    run_case(9615, 520, -1, 1'b0, 1'b0);   // R4 restart from midpoints

    check(exp_q.size() == 0, "R10 all completions seen", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule